// File: doc/BRIEF.md
# Tiled 2D Address Generator

This block maps a pixel coordinate inside a two-dimensional tiled container to a byte address. The container is built from slots: a parameter sets how many slot columns and rows it has (as bit counts), and another pair of parameters sets the pixel size of a slot. The pixel format chooses how many low bits of each coordinate fold into the slot, so wider pixels give narrower coordinate fields.

The address can be seen through any of eight views. Each view is a mix of three controls: mirror across X, mirror across Y, and transpose. The result is the packed offset, moved up by the format's alignment. The format and view bits sit above the offset, so each view has its own address window. The line stride for the chosen format and view is returned next to the address.

A request is taken on any clock edge where `req_valid` is high. The response appears on the next edge with `rsp_valid` high for one cycle. `rsp_ok` low means the coordinate or format was rejected.

Top module: `tile_addr_gen`

## Requirements
- R1: A request accepted on a clock edge gives `rsp_valid` high after exactly that edge, and `rsp_valid` is low in any cycle that follows an edge without a request.
- R2: Format codes are 0 = 1-byte pixel (x shift 0, y shift 0), 1 = 2-byte pixel (0,1), 2 = 4-byte pixel (1,1), 3 = page format (x shift SLOT_W_BITS, y shift SLOT_H_BITS). The x field has PX_W - xshift bits and the y field has PX_H - yshift bits, where PX_W = SLOT_W_BITS + CONT_W_BITS and PX_H = SLOT_H_BITS + CONT_H_BITS. Without orientation controls the offset is y * 2^xfield + x.
- R3: A coordinate above its field mask gives `rsp_ok` = 0, `rsp_addr` = 0 and `rsp_stride` = 0.
- R4: Format codes 4 to 7 give `rsp_ok` = 0, `rsp_addr` = 0 and `rsp_stride` = 0.
- R5: Orientation bit 0 (mirror X) replaces x with x XOR the x field mask.
- R6: Orientation bit 1 (mirror Y) replaces y with y XOR the y field mask.
- R7: Orientation bit 2 (transpose) makes the offset x * 2^yfield + y.
- R8: The packed offset is multiplied by 2^(xshift + yshift) and placed in address bits [PX_W+PX_H-1:0].
- R9: The stride is 2^(PX_H + xshift) when transposed and 2^(PX_W + yshift) otherwise, so exactly one bit is set when `rsp_ok` is high.
- R10: On an accepted request, address bits [PX_W+PX_H+2 : PX_W+PX_H] hold the orientation vector and the two bits above them hold format bits [1:0].
- R11: While reset is high and after it, until the first response, `rsp_valid`, `rsp_ok`, `rsp_addr` and `rsp_stride` are zero.
- R12: A cycle without a request leaves `rsp_ok`, `rsp_addr` and `rsp_stride` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_fmt | input | 3 | Pixel format code |
| req_orient | input | 3 | View controls: bit0 mirror X, bit1 mirror Y, bit2 transpose |
| req_x | input | SLOT_W_BITS+CONT_W_BITS | Pixel column |
| req_y | input | SLOT_H_BITS+CONT_H_BITS | Pixel row |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_ok | output | 1 | Request accepted (format and coordinate in range) |
| rsp_addr | output | PX_W+PX_H+5 | Byte address with view window bits |
| rsp_stride | output | PX_W+PX_H | Line stride in bytes |

## Verification
The bench uses the default parameters: 64 by 64 pixel slots and 256 by 128 slots. That gives 14-bit x and 13-bit y coordinates and a 32-bit address. With these values, the page format's shift of six bits on each axis reduces the fields to 8 and 7 bits. Random coordinates across the full port width therefore often exceed the page and 4-byte masks, which exercises rejection as much as mapping. The largest stride, 2^20, and a fully packed 27-bit offset are both reachable, so the extreme corners of every view are checked.

// File: rtl/tile_addr_pkg.sv
package tile_addr_pkg;

    localparam int FMT_W     = 3;
    localparam int ORIENT_W  = 3;
    localparam int SHIFT_W   = 6;

    typedef enum logic [FMT_W-1:0] {
        FMT_PIX8  = 3'd0,
        FMT_PIX16 = 3'd1,
        FMT_PIX32 = 3'd2,
        FMT_PAGE  = 3'd3
    } pix_fmt_e;

    typedef struct packed {
        logic               mirror_x;
        logic               mirror_y;
        logic               transpose;
    } view_t;

    typedef struct packed {
        logic               known;
        logic [SHIFT_W-1:0] xs;
        logic [SHIFT_W-1:0] ys;
    } fmt_geom_t;

    function automatic view_t unpack_view(input logic [ORIENT_W-1:0] o);
        view_t v;
        v.mirror_x  = o[0];
        v.mirror_y  = o[1];
        v.transpose = o[2];
        return v;
    endfunction

    function automatic fmt_geom_t lookup_geom(input logic [FMT_W-1:0] code,
                                              input int slot_w_bits,
                                              input int slot_h_bits);
        fmt_geom_t g;
        g = '0;
        unique case (code)
            FMT_PIX8:  begin g.known = 1'b1; g.xs = '0; g.ys = '0; end
            FMT_PIX16: begin g.known = 1'b1; g.xs = '0; g.ys = 6'd1; end
            FMT_PIX32: begin g.known = 1'b1; g.xs = 6'd1; g.ys = 6'd1; end
            FMT_PAGE:  begin
                g.known = 1'b1;
                g.xs    = SHIFT_W'(slot_w_bits);
                g.ys    = SHIFT_W'(slot_h_bits);
            end
            default:   g = '0;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/tile_fmt_decode.sv
module tile_fmt_decode
    import tile_addr_pkg::*;
#(
    parameter int SLOT_W_BITS = 6,
    parameter int SLOT_H_BITS = 6
) (
    input  logic [FMT_W-1:0] fmt,
    output fmt_geom_t        geom
);
    always_comb begin
        geom = lookup_geom(fmt, SLOT_W_BITS, SLOT_H_BITS);
    end
endmodule

// File: rtl/tile_ofs_calc.sv
module tile_ofs_calc
    import tile_addr_pkg::*;
#(
    parameter int PX_W = 14,
    parameter int PX_H = 13,
    localparam int OFS_W = PX_W + PX_H
) (
    input  logic [PX_W-1:0]    x,
    input  logic [PX_H-1:0]    y,
    input  view_t              view,
    input  fmt_geom_t          geom,
    output logic               in_range,
    output logic [OFS_W-1:0]   ofs,
    output logic [OFS_W-1:0]   stride
);
    logic [PX_W-1:0]    xmask;
    logic [PX_H-1:0]    ymask;
    logic [SHIFT_W-1:0] xbits, ybits;
    logic [PX_W-1:0]    xv;
    logic [PX_H-1:0]    yv;
    logic [OFS_W-1:0]   xe, ye, packed_ofs;
    logic [SHIFT_W:0]   align;

    always_comb begin
        xbits    = SHIFT_W'(PX_W) - geom.xs;
        ybits    = SHIFT_W'(PX_H) - geom.ys;
        xmask    = {PX_W{1'b1}} >> geom.xs;
        ymask    = {PX_H{1'b1}} >> geom.ys;
        in_range = (x <= xmask) && (y <= ymask);
        xv       = view.mirror_x ? (x ^ xmask) : x;
        yv       = view.mirror_y ? (y ^ ymask) : y;
        xe       = OFS_W'(xv);
        ye       = OFS_W'(yv);
        if (view.transpose)
            packed_ofs = (xe << ybits) | ye;
        else
            packed_ofs = (ye << xbits) | xe;
        align    = {1'b0, geom.xs} + {1'b0, geom.ys};
        ofs      = packed_ofs << align;
        if (view.transpose)
            stride = OFS_W'(1) << (SHIFT_W'(PX_H) + geom.xs);
        else
            stride = OFS_W'(1) << (SHIFT_W'(PX_W) + geom.ys);
    end
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
    import tile_addr_pkg::*;
#(
    parameter int SLOT_W_BITS = 6,
    parameter int SLOT_H_BITS = 6,
    parameter int CONT_W_BITS = 8,
    parameter int CONT_H_BITS = 7
) (
    input  logic                                                     clk,
    input  logic                                                     rst,
    input  logic                                                     req_valid,
    input  logic [2:0]                                               req_fmt,
    input  logic [2:0]                                               req_orient,
    input  logic [SLOT_W_BITS+CONT_W_BITS-1:0]                       req_x,
    input  logic [SLOT_H_BITS+CONT_H_BITS-1:0]                       req_y,
    output logic                                                     rsp_valid,
    output logic                                                     rsp_ok,
    output logic [SLOT_W_BITS+CONT_W_BITS+SLOT_H_BITS+CONT_H_BITS+4:0] rsp_addr,
    output logic [SLOT_W_BITS+CONT_W_BITS+SLOT_H_BITS+CONT_H_BITS-1:0] rsp_stride
);
    localparam int PX_W   = SLOT_W_BITS + CONT_W_BITS;
    localparam int PX_H   = SLOT_H_BITS + CONT_H_BITS;
    localparam int OFS_W  = PX_W + PX_H;
    localparam int ADDR_W = OFS_W + ORIENT_W + 2;

    fmt_geom_t         geom;
    view_t             view;
    logic              in_range;
    logic [OFS_W-1:0]  ofs, stride;
    logic              ok_next;

    assign view = unpack_view(req_orient);

    tile_fmt_decode #(
        .SLOT_W_BITS(SLOT_W_BITS),
        .SLOT_H_BITS(SLOT_H_BITS)
    ) u_dec (
        .fmt  (req_fmt),
        .geom (geom)
    );

    tile_ofs_calc #(
        .PX_W(PX_W),
        .PX_H(PX_H)
    ) u_calc (
        .x        (req_x),
        .y        (req_y),
        .view     (view),
        .geom     (geom),
        .in_range (in_range),
        .ofs      (ofs),
        .stride   (stride)
    );

    assign ok_next = geom.known && in_range;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_ok     <= 1'b0;
            rsp_addr   <= '0;
            rsp_stride <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_ok <= ok_next;
                if (ok_next) begin
                    rsp_addr   <= {req_fmt[1:0], req_orient, ofs};
                    rsp_stride <= stride;
                end else begin
                    rsp_addr   <= '0;
                    rsp_stride <= '0;
                end
            end
        end
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(rsp_addr) && $stable(rsp_ok) && $stable(rsp_stride)));
    assert_reject_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ok) |-> (rsp_addr == '0 && rsp_stride == '0));
    assert_badfmt_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_fmt[2]) |=> !rsp_ok);
    assert_stride_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_ok |-> ($countones(rsp_stride) == 1));
    assert_window_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!rsp_ok ||
            rsp_addr[ADDR_W-1:OFS_W] == {$past(req_fmt[1:0]), $past(req_orient)}));
endmodule

// File: tb/sim_tile_addr_gen.sv
`timescale 1ns/1ps
module sim_tile_addr_gen;
    localparam int SWB  = 6;
    localparam int SHB  = 6;
    localparam int CWB  = 8;
    localparam int CHB  = 7;
    localparam int PXW  = SWB + CWB;
    localparam int PXH  = SHB + CHB;
    localparam int OFSW = PXW + PXH;
    localparam int AW   = OFSW + 5;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic [2:0]      req_fmt = '0;
    logic [2:0]      req_orient = '0;
    logic [PXW-1:0]  req_x = '0;
    logic [PXH-1:0]  req_y = '0;
    logic            rsp_valid, rsp_ok;
    logic [AW-1:0]   rsp_addr;
    logic [OFSW-1:0] rsp_stride;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    tile_addr_gen #(
        .SLOT_W_BITS(SWB), .SLOT_H_BITS(SHB),
        .CONT_W_BITS(CWB), .CONT_H_BITS(CHB)
    ) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .req_fmt(req_fmt), .req_orient(req_orient),
        .req_x(req_x), .req_y(req_y),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .rsp_addr(rsp_addr), .rsp_stride(rsp_stride)
    );

    function automatic int fxs(input int f);
        return (f == 2) ? 1 : (f == 3) ? SWB : 0;
    endfunction
    function automatic int fys(input int f);
        return (f == 1 || f == 2) ? 1 : (f == 3) ? SHB : 0;
    endfunction

    function automatic void model(input int f, input int o, input longint x, input longint y,
                                  output logic ok, output logic [AW-1:0] a,
                                  output logic [OFSW-1:0] s);
        int xs, ys, xb, yb;
        longint xm, ym, xv, yv, lin;
        ok = 1'b0; a = '0; s = '0;
        if (f > 3) return;
        xs = fxs(f); ys = fys(f);
        xb = PXW - xs; yb = PXH - ys;
        xm = (longint'(1) << xb) - 1;
        ym = (longint'(1) << yb) - 1;
        if (x > xm || y > ym) return;
        ok = 1'b1;
        xv = o[0] ? (xm - x) : x;
        yv = o[1] ? (ym - y) : y;
        lin = o[2] ? (xv * (longint'(1) << yb) + yv) : (yv * (longint'(1) << xb) + xv);
        lin = lin * (longint'(1) << (xs + ys));
        a = AW'(lin) | (AW'(f % 4) << (OFSW + 3)) | (AW'(o) << OFSW);
        s = o[2] ? OFSW'(longint'(1) << (PXH + xs)) : OFSW'(longint'(1) << (PXW + ys));
    endfunction

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input int f, input int o, input longint x, input longint y,
                         input string tag);
        logic ok; logic [AW-1:0] a; logic [OFSW-1:0] s;
        model(f, o, x, y, ok, a, s);
        @(negedge clk);
        req_fmt = 3'(f); req_orient = 3'(o);
        req_x = PXW'(x); req_y = PXH'(y);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R1 valid"}, AW'(rsp_valid), AW'(1));
        chk({tag, " ok"}, AW'(rsp_ok), AW'(ok));
        chk({tag, " addr"}, rsp_addr, a);
        chk({tag, " stride"}, AW'(rsp_stride), AW'(s));
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [AW-1:0] held_a;
        logic [OFSW-1:0] held_s;
        logic held_ok;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 valid", AW'(rsp_valid), '0);
        chk("R11 ok", AW'(rsp_ok), '0);
        chk("R11 addr", rsp_addr, '0);
        chk("R11 stride", AW'(rsp_stride), '0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 after release", AW'(rsp_valid) | rsp_addr, '0);

        apply(0, 0, 5, 3, "R2 pix8");
        apply(1, 0, 100, 200, "R2 pix16");
        apply(0, 1, 0, 0, "R5 mirror x");
        apply(2, 2, 7, 0, "R6 mirror y");
        apply(1, 4, 9, 11, "R7 transpose");
        apply(2, 0, (1 << (PXW-1)) - 1, (1 << (PXH-1)) - 1, "R8 pix32 corner");
        apply(3, 0, 255, 127, "R8 page corner");
        apply(3, 7, 1, 2, "R9 page all views");
        apply(0, 4, (1 << PXW) - 1, (1 << PXH) - 1, "R9 transpose stride");
        apply(3, 0, 256, 0, "R3 page x over");
        apply(2, 0, 0, 1 << (PXH-1), "R3 pix32 y over");
        apply(5, 0, 1, 1, "R4 bad fmt");
        apply(7, 3, 0, 0, "R4 bad fmt 7");
        apply(1, 3, 12, 34, "R10 window");

        // R12: idle cycles leave outputs unchanged
        held_a = rsp_addr; held_s = rsp_stride; held_ok = rsp_ok;
        req_fmt = 3'd0; req_x = 13; req_y = 1; req_orient = 3'd5;
        @(negedge clk);
        chk("R12 valid low R1", AW'(rsp_valid), '0);
        chk("R12 addr held", rsp_addr, held_a);
        chk("R12 stride held", AW'(rsp_stride), AW'(held_s));
        chk("R12 ok held", AW'(rsp_ok), AW'(held_ok));

        for (int i = 0; i < 400; i++) begin
            int f, o, xb, yb;
            longint x, y;
            string tag;
            f = ($urandom % 10 == 0) ? 4 + int'($urandom % 4) : int'($urandom % 4);
            o = int'($urandom % 8);
            xb = PXW - ((f < 4) ? fxs(f) : 0);
            yb = PXH - ((f < 4) ? fys(f) : 0);
            if ($urandom % 4 == 0) begin
                x = longint'($urandom % (1 << PXW));
                y = longint'($urandom % (1 << PXH));
            end else begin
                x = longint'($urandom % (1 << xb));
                y = longint'($urandom % (1 << yb));
            end
            if (f > 3) tag = "R4 rand";
            else if (x >= (longint'(1) << xb) || y >= (longint'(1) << yb)) tag = "R3 rand";
            else if (o[2]) tag = "R7 rand";
            else if (o[0]) tag = "R5 rand";
            else if (o[1]) tag = "R6 rand";
            else tag = "R2 rand";
            apply(f, o, x, y, tag);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule